// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Mapper

This block is the control heart of a microcoded processor. It holds a microaddress register, a small microcode store written as a synthesizable case table, an opcode mapper, and next-address logic. Every clock edge the register loads a new microaddress. The microinstruction held at that address drives a control word out of the block. It also names one of four conditions and two successors: one taken when the condition is true and one taken when it is false.

A successor is one of three kinds: an absolute microaddress, the sequential address (current plus one), or the mapper result. The fetch routine uses the mapper result. The mapper takes a 9-bit code, made of one leading bit and two 4-bit fields. It compares the code against a prioritised list of patterns that may hold don't-care bits. A fully specified pattern placed ahead of a wildcard pattern overrides that wildcard for the one code it names. A code that no pattern matches goes to a fallback routine.

Top module: `useq_top`

## Requirements
- R1: While reset is asserted the microaddress is 0, the fetch routine, and the control word is 0x01.
- R2: In the fetch routine the next microaddress is the mapper's entry address for the current mapping code. The mapping code has no effect in any other routine: a change to it in the increment routine (address 4) does not alter its successor.
- R3: Wildcard groups map by the middle field when the leading bit is 0. Upper field 0 maps to load-via-N (address 2), 1 to increment (4), 2 to decrement (5), 3 to the short-branch routine (6) and 4 to load-advance (9). The control word in the increment routine is 0x12.
- R4: The code 0x000 maps to the idle routine (address 3) and not to the load-via-N routine that its wildcard group would select.
- R5: A code that matches no pattern maps to the fallback routine (address 10). This includes any code whose leading bit is 1.
- R6: Each microinstruction picks its successor with a 2-bit condition select: 00 always true, 01 continue, 10 branch condition, 11 DMA/interrupt pending. A condition that the current microinstruction does not select has no effect on the successor.
- R7: The load-via-N, increment, decrement, skip, branch-taken and fallback routines end by going to fetch (0) when continue is 1. Otherwise they go to the service routine (1).
- R8: The load-advance routine (9) goes on to the increment routine (4) whatever its inputs are.
- R9: The short-branch routine (6) goes to address 8 when the branch condition is 1. Otherwise it goes to the sequential address 7, the skip routine.
- R10: The idle routine (control word 0x11) stays at address 3 while pending is 0 and goes to the service routine (1) when pending is 1. The service routine always returns to fetch (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_code | input | MAP_W (9) | Instruction mapping code: leading bit, upper field, lower field |
| cond_cont | input | 1 | Continue condition |
| cond_branch | input | 1 | Branch condition |
| cond_pend | input | 1 | DMA or interrupt pending |
| uctrl | output | CTRL_W (8) | Control word of the current microinstruction |
| uaddr | output | UADDR_W (6) | Current microaddress |

## Verification
The assertions check these behaviours on every cycle: the reset address, the jump from fetch to the mapper's address, the exact override of code 0x000, the idle hold and exit, the service return, and the way the increment routine ends on the continue condition. Some behaviours only the bench scenarios can show. These are the wildcard group assignments, the fallback for unmatched and leading-bit codes, the branch with its sequential successor, the unconditional hop from load-advance to increment, and the fact that a mapping code changed outside fetch is never used.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      CS_ALWAYS = 2'd0,
      CS_CONT   = 2'd1,
      CS_BRANCH = 2'd2,
      CS_PEND   = 2'd3
   } csel_e;

   typedef enum logic [1:0] {
      TK_ABS = 2'd0,
      TK_SEQ = 2'd1,
      TK_MAP = 2'd2
   } tkind_e;

   localparam int unsigned A_FETCH    = 0;
   localparam int unsigned A_SVC      = 1;
   localparam int unsigned A_LDN      = 2;
   localparam int unsigned A_IDLE     = 3;
   localparam int unsigned A_INC      = 4;
   localparam int unsigned A_DEC      = 5;
   localparam int unsigned A_SBR      = 6;
   localparam int unsigned A_SKIP     = 7;
   localparam int unsigned A_SBR_TK   = 8;
   localparam int unsigned A_LDA      = 9;
   localparam int unsigned A_FALLBACK = 10;
   localparam int unsigned A_TOP      = A_FALLBACK;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
   import useq_pkg::*;
#(
   parameter int UADDR_W = 6,
   parameter int CTRL_W  = 8
) (
   input  logic [UADDR_W-1:0] uaddr,
   output logic [CTRL_W-1:0]  ctrl,
   output csel_e              csel,
   output tkind_e             kind_a,
   output logic [UADDR_W-1:0] addr_a,
   output tkind_e             kind_b,
   output logic [UADDR_W-1:0] addr_b
);
   localparam logic [UADDR_W-1:0] U_FETCH  = UADDR_W'(A_FETCH);
   localparam logic [UADDR_W-1:0] U_SVC    = UADDR_W'(A_SVC);
   localparam logic [UADDR_W-1:0] U_IDLE   = UADDR_W'(A_IDLE);
   localparam logic [UADDR_W-1:0] U_INC    = UADDR_W'(A_INC);
   localparam logic [UADDR_W-1:0] U_SBR_TK = UADDR_W'(A_SBR_TK);

   always_comb begin
      ctrl   = '0;
      csel   = CS_ALWAYS;
      kind_a = TK_ABS;
      addr_a = U_FETCH;
      kind_b = TK_ABS;
      addr_b = U_FETCH;
      case (uaddr)
         UADDR_W'(A_FETCH): begin
            ctrl   = CTRL_W'(8'h01);
            kind_a = TK_MAP;
            kind_b = TK_MAP;
         end
         UADDR_W'(A_SVC): begin
            ctrl = CTRL_W'(8'h02);
         end
         UADDR_W'(A_LDN): begin
            ctrl   = CTRL_W'(8'h10);
            csel   = CS_CONT;
            addr_b = U_SVC;
         end
         UADDR_W'(A_IDLE): begin
            ctrl   = CTRL_W'(8'h11);
            csel   = CS_PEND;
            addr_a = U_SVC;
            addr_b = U_IDLE;
         end
         UADDR_W'(A_INC): begin
            ctrl   = CTRL_W'(8'h12);
            csel   = CS_CONT;
            addr_b = U_SVC;
         end
         UADDR_W'(A_DEC): begin
            ctrl   = CTRL_W'(8'h13);
            csel   = CS_CONT;
            addr_b = U_SVC;
         end
         UADDR_W'(A_SBR): begin
            ctrl   = CTRL_W'(8'h14);
            csel   = CS_BRANCH;
            addr_a = U_SBR_TK;
            kind_b = TK_SEQ;
         end
         UADDR_W'(A_SKIP): begin
            ctrl   = CTRL_W'(8'h15);
            csel   = CS_CONT;
            addr_b = U_SVC;
         end
         UADDR_W'(A_SBR_TK): begin
            ctrl   = CTRL_W'(8'h16);
            csel   = CS_CONT;
            addr_b = U_SVC;
         end
         UADDR_W'(A_LDA): begin
            ctrl   = CTRL_W'(8'h17);
            addr_a = U_INC;
            addr_b = U_INC;
         end
         UADDR_W'(A_FALLBACK): begin
            ctrl   = CTRL_W'(8'h1F);
            csel   = CS_CONT;
            addr_b = U_SVC;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/useq_map.sv
module useq_map
   import useq_pkg::*;
#(
   parameter int MAP_W   = 9,
   parameter int UADDR_W = 6
) (
   input  logic [MAP_W-1:0]   code,
   output logic [UADDR_W-1:0] entry
);
   localparam int NENT = 6;

   // Lower index wins: exact patterns sit ahead of the wildcards they overlap.
   function automatic logic [MAP_W-1:0] pat_val(int i);
      case (i)
         0:       return MAP_W'(9'h000);
         1:       return MAP_W'(9'h000);
         2:       return MAP_W'(9'h010);
         3:       return MAP_W'(9'h020);
         4:       return MAP_W'(9'h030);
         default: return MAP_W'(9'h040);
      endcase
   endfunction

   function automatic logic [MAP_W-1:0] pat_care(int i);
      if (i == 0) return MAP_W'(9'h1FF);
      return MAP_W'(9'h1F0);
   endfunction

   function automatic logic [UADDR_W-1:0] pat_tgt(int i);
      case (i)
         0:       return UADDR_W'(A_IDLE);
         1:       return UADDR_W'(A_LDN);
         2:       return UADDR_W'(A_INC);
         3:       return UADDR_W'(A_DEC);
         4:       return UADDR_W'(A_SBR);
         default: return UADDR_W'(A_LDA);
      endcase
   endfunction

   logic [NENT-1:0] hit;

   for (genvar g = 0; g < NENT; g++) begin : g_pat
      assign hit[g] = ((code ^ pat_val(g)) & pat_care(g)) == '0;
   end

   always_comb begin
      entry = UADDR_W'(A_FALLBACK);
      for (int i = NENT - 1; i >= 0; i--) begin
         if (hit[i]) entry = pat_tgt(i);
      end
   end
endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UADDR_W = 6
) (
   input  logic [UADDR_W-1:0] uaddr,
   input  csel_e              csel,
   input  tkind_e             kind_a,
   input  logic [UADDR_W-1:0] addr_a,
   input  tkind_e             kind_b,
   input  logic [UADDR_W-1:0] addr_b,
   input  logic [UADDR_W-1:0] map_entry,
   input  logic               cond_cont,
   input  logic               cond_branch,
   input  logic               cond_pend,
   output logic [UADDR_W-1:0] nxt
);
   logic               cond;
   tkind_e             kind;
   logic [UADDR_W-1:0] tgt;

   always_comb begin
      case (csel)
         CS_CONT:   cond = cond_cont;
         CS_BRANCH: cond = cond_branch;
         CS_PEND:   cond = cond_pend;
         default:   cond = 1'b1;
      endcase
      kind = cond ? kind_a : kind_b;
      tgt  = cond ? addr_a : addr_b;
      case (kind)
         TK_ABS:  nxt = tgt;
         TK_SEQ:  nxt = uaddr + UADDR_W'(1);
         TK_MAP:  nxt = map_entry;
         default: nxt = UADDR_W'(A_FETCH);
      endcase
   end
endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int MAP_W     = 9,
   parameter int UADDR_W   = 6,
   parameter int CTRL_W    = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MAP_W-1:0]   map_code,
   input  logic               cond_cont,
   input  logic               cond_branch,
   input  logic               cond_pend,
   output logic [CTRL_W-1:0]  uctrl,
   output logic [UADDR_W-1:0] uaddr
);
   if (MAP_W != 9) begin : g_bad_map_w
      $error("useq_top: MAP_W must be 9");
   end
   if ((1 << UADDR_W) <= A_TOP) begin : g_bad_uaddr_w
      $error("useq_top: UADDR_W too small for the routine layout");
   end
   if (CTRL_W < 8) begin : g_bad_ctrl_w
      $error("useq_top: CTRL_W must be at least 8");
   end

   csel_e              csel;
   tkind_e             kind_a, kind_b;
   logic [UADDR_W-1:0] addr_a, addr_b, map_addr, nxt;

   useq_rom #(.UADDR_W(UADDR_W), .CTRL_W(CTRL_W)) u_rom (
      .uaddr (uaddr),
      .ctrl  (uctrl),
      .csel  (csel),
      .kind_a(kind_a),
      .addr_a(addr_a),
      .kind_b(kind_b),
      .addr_b(addr_b)
   );

   useq_map #(.MAP_W(MAP_W), .UADDR_W(UADDR_W)) u_map (
      .code (map_code),
      .entry(map_addr)
   );

   useq_next #(.UADDR_W(UADDR_W)) u_next (
      .uaddr      (uaddr),
      .csel       (csel),
      .kind_a     (kind_a),
      .addr_a     (addr_a),
      .kind_b     (kind_b),
      .addr_b     (addr_b),
      .map_entry  (map_addr),
      .cond_cont  (cond_cont),
      .cond_branch(cond_branch),
      .cond_pend  (cond_pend),
      .nxt        (nxt)
   );

   if (ASYNC_RST) begin : g_areg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) uaddr <= UADDR_W'(A_FETCH);
         else        uaddr <= nxt;
      end
   end else begin : g_sreg
      always_ff @(posedge clk) begin
         if (!rst_n) uaddr <= UADDR_W'(A_FETCH);
         else        uaddr <= nxt;
      end
   end
endmodule

// File: rtl/useq_chk.sv
module useq_chk
   import useq_pkg::*;
#(
   parameter int MAP_W   = 9,
   parameter int UADDR_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [MAP_W-1:0]   map_code,
   input logic               cond_cont,
   input logic               cond_pend,
   input logic [UADDR_W-1:0] uaddr,
   input logic [UADDR_W-1:0] map_addr
);
   localparam logic [UADDR_W-1:0] U_FETCH = UADDR_W'(A_FETCH);
   localparam logic [UADDR_W-1:0] U_SVC   = UADDR_W'(A_SVC);
   localparam logic [UADDR_W-1:0] U_IDLE  = UADDR_W'(A_IDLE);
   localparam logic [UADDR_W-1:0] U_INC   = UADDR_W'(A_INC);

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_fetch: assert (uaddr == U_FETCH);
      end
   end

   a_r2_fetch_takes_map: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == U_FETCH) |=> (uaddr == $past(map_addr)));

   a_r4_exact_override: assert property (@(posedge clk) disable iff (!rst_n)
      (map_code == '0) |-> (map_addr == U_IDLE));

   a_r7_end_continue: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == U_INC && cond_cont) |=> (uaddr == U_FETCH));

   a_r7_end_service: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == U_INC && !cond_cont) |=> (uaddr == U_SVC));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == U_IDLE && !cond_pend) |=> (uaddr == U_IDLE));

   a_r10_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == U_IDLE && cond_pend) |=> (uaddr == U_SVC));

   a_r10_service_return: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr == U_SVC) |=> (uaddr == U_FETCH));
endmodule

bind useq_top useq_chk #(.MAP_W(MAP_W), .UADDR_W(UADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .map_code (map_code),
   .cond_cont(cond_cont),
   .cond_pend(cond_pend),
   .uaddr    (uaddr),
   .map_addr (map_addr)
);

// File: tb/sim_useq_top.sv
module sim_useq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] map_code = 9'h000;
   logic       cond_cont = 1'b1;
   logic       cond_branch = 1'b0;
   logic       cond_pend = 1'b0;
   logic [7:0] uctrl;
   logic [5:0] uaddr;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   useq_top u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .map_code   (map_code),
      .cond_cont  (cond_cont),
      .cond_branch(cond_branch),
      .cond_pend  (cond_pend),
      .uctrl      (uctrl),
      .uaddr      (uaddr)
   );

   task automatic check(string req, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 reset address", uaddr, 0);
      check("R1 reset control", uctrl, 8'h01);
      rst_n = 1'b1;
      check("R1 fetch after release", uaddr, 0);
   endtask

   task automatic t_group(logic [8:0] code, int entry, logic cont);
      map_code  = code;
      cond_cont = cont;
      tick();
      check("R3 group entry", uaddr, entry);
      tick();
      check("R7 end of instruction", uaddr, cont ? 0 : 1);
      if (!cont) begin
         tick();
         check("R10 service return", uaddr, 0);
      end
      cond_cont = 1'b1;
   endtask

   task automatic t_idle();
      map_code  = 9'h000;
      cond_pend = 1'b0;
      tick();
      check("R4 exact override", uaddr, 3);
      check("R10 idle control", uctrl, 8'h11);
      map_code = 9'h010;
      for (int i = 0; i < 3; i++) begin
         tick();
         check("R10 idle hold", uaddr, 3);
      end
      cond_pend = 1'b1;
      tick();
      check("R10 idle exit", uaddr, 1);
      cond_pend = 1'b0;
      tick();
      check("R10 service return", uaddr, 0);
   endtask

   task automatic t_branch(logic br);
      map_code    = 9'h033;
      cond_branch = br;
      tick();
      check("R3 branch entry", uaddr, 6);
      cond_cont = 1'b0;
      cond_pend = 1'b1;
      tick();
      check(br ? "R6 branch taken" : "R9 sequential successor", uaddr, br ? 8 : 7);
      cond_cont   = 1'b1;
      cond_pend   = 1'b0;
      cond_branch = ~br;
      tick();
      check("R6 only continue selected", uaddr, 0);
      cond_branch = 1'b0;
   endtask

   task automatic t_lda();
      map_code = 9'h04A;
      tick();
      check("R3 load-advance entry", uaddr, 9);
      cond_cont = 1'b0;
      cond_branch = 1'b1;
      cond_pend = 1'b1;
      tick();
      check("R8 goto increment", uaddr, 4);
      cond_cont = 1'b1;
      cond_branch = 1'b0;
      cond_pend = 1'b0;
      check("R3 increment control", uctrl, 8'h12);
      tick();
      check("R7 back to fetch", uaddr, 0);
   endtask

   task automatic t_fallback(logic [8:0] code);
      map_code = code;
      tick();
      check("R5 fallback entry", uaddr, 10);
      tick();
      check("R7 fallback end", uaddr, 0);
   endtask

   task automatic t_ignore();
      map_code = 9'h01C;
      tick();
      check("R2 increment entry", uaddr, 4);
      map_code = 9'h000;
      tick();
      check("R2 code ignored outside fetch", uaddr, 0);
      map_code = 9'h02F;
      tick();
      check("R2 fetch uses current code", uaddr, 5);
      tick();
      check("R7 decrement end", uaddr, 0);
   endtask

   initial begin
      t_reset();
      t_group(9'h015, 4, 1'b1);
      t_group(9'h015, 4, 1'b0);
      t_group(9'h007, 2, 1'b1);
      t_group(9'h02A, 5, 1'b0);
      t_idle();
      t_branch(1'b1);
      t_branch(1'b0);
      t_lda();
      t_fallback(9'h100);
      t_fallback(9'h1FF);
      t_fallback(9'h0F0);
      t_fallback(9'h050);
      t_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule